// File: doc/BRIEF.md
# Chroma 4:2:2 Subsample Multiplexer

This block sits between a full-rate luma/chroma pixel stream and a compression core. It works in two directions. In the packing direction it takes one luma sample and one sample of each chroma component per pixel. It keeps the chroma pair of every even pixel, drops the pair of every odd pixel, and sends the kept Cr and Cb one after the other on a single chroma lane that runs beside luma. In the unpacking direction it takes the interleaved lane, splits it back into two components and rebuilds full-rate chroma by holding each received value for two pixels.

A per-pixel direction bit and a four-bit pixel format code go with each beat. Only two format codes turn the conversion on. Every other code sends all three lanes through untouched. The even/odd pixel phase restarts at a start-of-line marker, so chroma pairing never carries over from one line to the next. Luma is 8-bit unsigned and chroma is 8-bit two's complement. The block never changes sample values, so signedness has no effect on how it behaves. Every beat leaves the block exactly two clock cycles after it enters. Luma is only delayed.

Top module: `chroma422_mux`

## Requirements
- R1: With conversion active and `encode`=1, a pixel at an even position within its line (position 0 is the pixel flagged by `in_sol`) emits its own Cr (`in_c0`) on `out_c0`. The Cr and Cb of odd-position pixels never appear at the output.
- R2: With conversion active and `encode`=1, an odd-position pixel emits on `out_c0` the Cb (`in_c1`) of the even pixel just before it. In this mode `out_c1` is driven to zero.
- R3: With conversion active and `encode`=0, the lane input is `in_c0`. An even-position pixel emits its own lane value as Cr on `out_c0`, and as Cb on `out_c1` the lane value of the pixel that follows it in the same line.
- R4: With conversion active and `encode`=0, an odd-position pixel repeats on `out_c0` the Cr of the preceding even pixel and emits its own lane value as Cb on `out_c1`.
- R5: With conversion active and `encode`=0, when an even-position pixel is not followed in the next cycle by a valid pixel of the same line, its Cb repeats the last Cb that the unpacking path emitted (zero after reset).
- R6: The pixel flagged by `in_sol` is always at an even position, even when the line before it had an odd number of pixels. So every line starts with Cr on the chroma lane.
- R7: Conversion is active only for format codes 4'h7 and 4'h6. Any other code (for example 4'h4, 4'h0 or 4'h5) passes `in_y`, `in_c0` and `in_c1` unchanged to `out_y`, `out_c0` and `out_c1`.
- R8: `encode` and `fmt` are taken per pixel with that pixel's data. A value of 1 selects packing and 0 selects unpacking.
- R9: `out_valid` equals `in_valid` delayed by exactly two clock cycles, and `out_y` is `in_y` of the same beat, unchanged.
- R10: While `rst_n` is low, `out_valid`, `out_y`, `out_c0` and `out_c1` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| encode | input | 1 | 1: pack to 4:2:2, 0: unpack to full rate |
| fmt | input | 4 | Pixel format code; 4'h7 and 4'h6 enable conversion |
| in_valid | input | 1 | Input beat valid |
| in_sol | input | 1 | Input beat is the first active pixel of a line |
| in_y | input | DW | Luma in |
| in_c0 | input | DW | Cr in (packing) or interleaved chroma lane (unpacking) |
| in_c1 | input | DW | Cb in (packing); used only in bypass otherwise |
| out_valid | output | 1 | Output beat valid |
| out_y | output | DW | Luma out |
| out_c0 | output | DW | Interleaved lane (packing) or Cr (unpacking) |
| out_c1 | output | DW | Zero (packing) or Cb (unpacking) |

## Verification
The bench builds the block with its default sample width of 8 bits. At that width the chroma values it drives cover both halves of the two's complement range, so any sign handling would show up as a changed value. Lines of both odd and even length are sent back to back in both directions. This exercises the phase restart at `in_sol` and the case where a line ends on an even pixel with no partner. The four-bit format code is driven with both active codes and with three bypass codes, including one code that has no defined meaning.

// File: rtl/c422_pkg.sv
package c422_pkg;
   localparam int FMT_W = 4;
   localparam logic [FMT_W-1:0] FMT_RGB = 4'h7;
   localparam logic [FMT_W-1:0] FMT_YCC = 4'h6;

   typedef enum logic {
      DIR_UNPACK = 1'b0,
      DIR_PACK   = 1'b1
   } dir_e;

   function automatic logic fmt_converts(input logic [FMT_W-1:0] f);
      return (f == FMT_RGB) || (f == FMT_YCC);
   endfunction
endpackage

// File: rtl/c422_stage.sv
module c422_stage
   import c422_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LANES = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        encode,
   input  logic [FMT_W-1:0]            fmt,
   input  logic                        in_valid,
   input  logic                        in_sol,
   input  logic [LANES-1:0][DW-1:0]    in_px,
   output logic                        s_valid,
   output logic                        s_even,
   output logic                        s_enc,
   output logic                        s_act,
   output logic [LANES-1:0][DW-1:0]    s_px
);
   if (DW < 1) begin : g_bad_dw
      $error("c422_stage: DW must be at least 1");
   end
   if (LANES != 3) begin : g_bad_lanes
      $error("c422_stage: exactly three lanes are supported");
   end

   logic prev_even;
   logic even_now;

   // Phase restarts at a line start, otherwise alternates per valid beat.
   assign even_now = in_sol | ~prev_even;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_even <= 1'b0;
         s_valid   <= 1'b0;
         s_even    <= 1'b0;
         s_enc     <= 1'b0;
         s_act     <= 1'b0;
      end else begin
         s_valid <= in_valid;
         if (in_valid) begin
            prev_even <= even_now;
            s_even    <= even_now;
            s_enc     <= (dir_e'(encode) == DIR_PACK);
            s_act     <= fmt_converts(fmt);
         end
      end
   end

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_px[ln] <= '0;
         end else if (in_valid) begin
            s_px[ln] <= in_px[ln];
         end
      end
   end

   assert_sol_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_sol) |-> s_even);
endmodule

// File: rtl/c422_pack.sv
module c422_pack #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_valid,
   input  logic          s_even,
   input  logic          s_upd,
   input  logic [DW-1:0] s_cr,
   input  logic [DW-1:0] s_cb,
   output logic [DW-1:0] lane
);
   if (DW < 1) begin : g_bad_dw
      $error("c422_pack: DW must be at least 1");
   end

   logic [DW-1:0] cb_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cb_hold <= '0;
      end else if (s_valid && s_upd && s_even) begin
         cb_hold <= s_cb;
      end
   end

   assign lane = s_even ? s_cr : cb_hold;

   assert_odd_slot_cb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_upd && !s_even && $past(s_valid && s_upd && s_even))
      |-> lane == $past(s_cb));
endmodule

// File: rtl/c422_unpack.sv
module c422_unpack #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_valid,
   input  logic          s_even,
   input  logic          s_upd,
   input  logic [DW-1:0] s_lane,
   input  logic          nxt_ok,
   input  logic [DW-1:0] nxt_lane,
   output logic [DW-1:0] cr,
   output logic [DW-1:0] cb
);
   if (DW < 1) begin : g_bad_dw
      $error("c422_unpack: DW must be at least 1");
   end

   logic [DW-1:0] cr_hold;
   logic [DW-1:0] cb_last;

   always_comb begin
      if (s_even) begin
         cr = s_lane;
         cb = nxt_ok ? nxt_lane : cb_last;
      end else begin
         cr = cr_hold;
         cb = s_lane;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_hold <= '0;
         cb_last <= '0;
      end else if (s_valid && s_upd) begin
         if (s_even) cr_hold <= s_lane;
         cb_last <= cb;
      end
   end

   assert_hold_cr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_upd && !s_even && $past(s_valid && s_upd && s_even))
      |-> cr == $past(s_lane));

   assert_tail_cb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_upd && s_even && !nxt_ok && $past(s_valid && s_upd && !s_even))
      |-> cb == $past(s_lane));
endmodule

// File: rtl/chroma422_mux.sv
module chroma422_mux
   import c422_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             encode,
   input  logic [3:0]       fmt,
   input  logic             in_valid,
   input  logic             in_sol,
   input  logic [DW-1:0]    in_y,
   input  logic [DW-1:0]    in_c0,
   input  logic [DW-1:0]    in_c1,
   output logic             out_valid,
   output logic [DW-1:0]    out_y,
   output logic [DW-1:0]    out_c0,
   output logic [DW-1:0]    out_c1
);
   localparam int LANES = 3;
   localparam int LY = 0;
   localparam int LA = 1;
   localparam int LB = 2;

   if (FMT_W != 4) begin : g_bad_fmt
      $error("chroma422_mux: format code width must be 4");
   end

   logic [LANES-1:0][DW-1:0] in_px;
   logic [LANES-1:0][DW-1:0] s_px;
   logic s_valid, s_even, s_enc, s_act;
   logic [DW-1:0] pk_lane, up_cr, up_cb;
   logic nxt_ok;

   assign in_px[LY] = in_y;
   assign in_px[LA] = in_c0;
   assign in_px[LB] = in_c1;
   assign nxt_ok    = in_valid && !in_sol;

   c422_stage #(.DW(DW), .LANES(LANES)) u_stage (
      .clk(clk), .rst_n(rst_n), .encode(encode), .fmt(fmt),
      .in_valid(in_valid), .in_sol(in_sol), .in_px(in_px),
      .s_valid(s_valid), .s_even(s_even), .s_enc(s_enc), .s_act(s_act),
      .s_px(s_px)
   );

   c422_pack #(.DW(DW)) u_pack (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_even(s_even),
      .s_upd(s_act && s_enc), .s_cr(s_px[LA]), .s_cb(s_px[LB]),
      .lane(pk_lane)
   );

   c422_unpack #(.DW(DW)) u_unpack (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_even(s_even),
      .s_upd(s_act && !s_enc), .s_lane(s_px[LA]),
      .nxt_ok(nxt_ok), .nxt_lane(in_c0),
      .cr(up_cr), .cb(up_cb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_c0    <= '0;
         out_c1    <= '0;
      end else begin
         out_valid <= s_valid;
         if (s_valid) begin
            out_y <= s_px[LY];
            if (!s_act) begin
               out_c0 <= s_px[LA];
               out_c1 <= s_px[LB];
            end else if (s_enc) begin
               out_c0 <= pk_lane;
               out_c1 <= '0;
            end else begin
               out_c0 <= up_cr;
               out_c1 <= up_cb;
            end
         end
      end
   end

   assert_fixed_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 2));

   assert_luma_unchanged_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid, 2) |-> out_y == $past(in_y, 2));

   assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !fmt_converts(fmt), 2)
      |-> (out_c0 == $past(in_c0, 2)) && (out_c1 == $past(in_c1, 2)));

   assert_line_starts_cr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_sol && encode && fmt_converts(fmt), 2)
      |-> (out_c0 == $past(in_c0, 2)) && (out_c1 == '0));
endmodule

// File: tb/sim_chroma422_mux.sv
module sim_chroma422_mux;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic encode = 1'b0;
   logic [3:0] fmt = 4'h0;
   logic in_valid = 1'b0;
   logic in_sol = 1'b0;
   logic [DW-1:0] in_y = '0, in_c0 = '0, in_c1 = '0;
   logic out_valid;
   logic [DW-1:0] out_y, out_c0, out_c1;

   always #(CLK_PERIOD/2) clk = ~clk;

   chroma422_mux #(.DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .encode(encode), .fmt(fmt),
      .in_valid(in_valid), .in_sol(in_sol),
      .in_y(in_y), .in_c0(in_c0), .in_c1(in_c1),
      .out_valid(out_valid), .out_y(out_y), .out_c0(out_c0), .out_c1(out_c1)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad = 0;

   logic [DW-1:0] ey[64], ec0[64], ec1[64];
   int ecyc[64];
   int en = 0;
   logic [DW-1:0] my[64], mc0[64], mc1[64];
   int mcyc[64];
   int mn = 0;
   logic [DW-1:0] lastcb = '0;

   always @(negedge clk) begin
      if (rst_n && out_valid && mn < 64) begin
         my[mn] = out_y; mc0[mn] = out_c0; mc1[mn] = out_c1; mcyc[mn] = cyc;
         mn = mn + 1;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic send(input logic enc, input logic [3:0] f, input logic sol,
                       input logic [DW-1:0] y, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] xc0, input logic [DW-1:0] xc1);
      encode = enc; fmt = f; in_valid = 1'b1; in_sol = sol;
      in_y = y; in_c0 = a; in_c1 = b;
      if (en < 64) begin
         ey[en] = y; ec0[en] = xc0; ec1[en] = xc1; ecyc[en] = cyc + 2;
         en = en + 1;
      end
      @(negedge clk);
   endtask

   // One line of len pixels, expected values from R1..R7
   task automatic line(input logic enc, input logic [3:0] f, input int len, input int seed);
      logic [DW-1:0] ya[16], aa[16], ba[16];
      logic act;
      logic [DW-1:0] xc0, xc1;
      act = (f == 4'h7) || (f == 4'h6);
      for (int i = 0; i < len; i++) begin
         ya[i] = DW'(seed * 31 + i * 17 + 3);
         aa[i] = DW'(seed * 53 + i * 29 + 128);
         ba[i] = DW'(seed * 11 + i * 41 + 200);
      end
      for (int i = 0; i < len; i++) begin
         if (!act) begin
            xc0 = aa[i]; xc1 = ba[i];
         end else if (enc) begin
            xc0 = (i % 2 == 0) ? aa[i] : ba[i-1];
            xc1 = '0;
         end else begin
            if (i % 2 == 0) begin
               xc0 = aa[i];
               xc1 = (i + 1 < len) ? aa[i+1] : lastcb;
            end else begin
               xc0 = aa[i-1];
               xc1 = aa[i];
            end
            lastcb = xc1;
         end
         send(enc, f, (i == 0), ya[i], aa[i], ba[i], xc0, xc1);
      end
   endtask

   task automatic settle_and_compare(input string req);
      in_valid = 1'b0; in_sol = 1'b0;
      repeat (4) @(negedge clk);
      chk(req, "beat count", mn, en);
      for (int i = 0; i < en && i < mn; i++) begin
         chk(req, $sformatf("beat %0d y", i), my[i], ey[i]);
         chk(req, $sformatf("beat %0d c0", i), mc0[i], ec0[i]);
         chk(req, $sformatf("beat %0d c1", i), mc1[i], ec1[i]);
         chk("R9", $sformatf("beat %0d cycle", i), mcyc[i], ecyc[i]);
      end
      en = 0; mn = 0;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; in_valid = 1'b1; in_y = 8'hA5; in_c0 = 8'h5A; in_c1 = 8'h3C;
      repeat (3) @(negedge clk);
      chk("R10", "out_valid in reset", out_valid, 0);
      chk("R10", "out_y in reset", out_y, 0);
      chk("R10", "out_c0 in reset", out_c0, 0);
      chk("R10", "out_c1 in reset", out_c1, 0);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mn = 0; en = 0;
   endtask

   task automatic t_pack_rgb;      // R1 R2 R8
      line(1'b1, 4'h7, 8, 1);
      settle_and_compare("R1 R2 R8");
   endtask

   task automatic t_pack_odd_lines; // R6 R1
      line(1'b1, 4'h6, 5, 2);
      line(1'b1, 4'h6, 4, 3);
      settle_and_compare("R6 R1");
   endtask

   task automatic t_unpack_line;   // R3 R4 R8
      line(1'b0, 4'h6, 8, 4);
      settle_and_compare("R3 R4 R8");
   endtask

   task automatic t_unpack_tail;   // R5 R6
      line(1'b0, 4'h7, 5, 5);
      line(1'b0, 4'h7, 3, 6);
      settle_and_compare("R5 R6");
   endtask

   task automatic t_bypass;        // R7
      line(1'b1, 4'h4, 4, 7);
      line(1'b0, 4'h0, 3, 8);
      line(1'b1, 4'h5, 3, 9);
      settle_and_compare("R7");
   endtask

   task automatic t_mixed;         // R8: direction switches per pixel stream
      line(1'b0, 4'h6, 4, 10);
      line(1'b1, 4'h6, 4, 11);
      line(1'b0, 4'h6, 2, 12);
      settle_and_compare("R8 R9");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_pack_rgb();
      t_pack_odd_lines();
      t_unpack_line();
      t_unpack_tail();
      t_bypass();
      t_mixed();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule